// File: doc/BRIEF.md
# Half-Duplex Transmit Backoff and Deferral Timer

This block decides when a half-duplex Ethernet transmitter may start a frame. A frame request first waits for the carrier to stay quiet for an interframe gap. After a collision, the retry indication carries the attempt number. The block then waits a random number of slot times before it defers again. The random wait is a truncated binary exponential backoff. Its exponent is the attempt number, capped by a 2-bit limit select. One slot is 512 bit-time ticks. The random value comes from a free-running LFSR whose seed is a parameter.

An optional watchdog measures how long a frame has been deferring. If the deferral lasts too long, the block reports an excessive-deferral error, aborts the request and drops back to idle. Each new carrier assertion restarts the watchdog. In full-duplex mode the block never holds the transmitter back. Frame serialization, CRC, collision detection, jam and register access are handled elsewhere.

Top module: `hd_txtime`

## Requirements
- R1: After reset in half-duplex mode, `tx_ok`, `bo_busy`, `defer_err` and `tx_abort` are all low.
- R2: While `full_duplex` is high, `tx_ok` is high and `bo_busy` stays low, and `retry` pulses have no effect.
- R3: A rising edge of `tx_req` starts a deferral. With `crs` low and one tick per clock, `tx_ok` rises on the 97th clock after the clock that sampled the edge. That count is the clock that samples the edge followed by IFG_TICKS = 96 quiet ticks.
- R4: A `retry` pulse with a nonzero `attempt_n`, taken while a request is active, makes `bo_busy` high for dt*512 ticks plus one clock. The random delay dt satisfies 0 <= dt < 2^k, where k = min(attempt_n, cap). The cap is 10, 8, 4 or 1 for `bo_sel` = 0, 1, 2 or 3. After the backoff ends, the normal deferral of R3 follows.
- R5: A `retry` with `attempt_n` = 0 causes no backoff. `bo_busy` stays low, and `tx_ok` rises 97 clocks later, as in R3.
- R6: With `defer_chk_en` high, `defer_err` and `tx_abort` pulse together for exactly one clock on the 24289th consecutive deferral tick without a carrier restart. In the bench that is 24290 clocks after the request edge.
- R7: A rising edge of `crs` during deferral restarts both the deferral timer and the gap. The error then comes 24290 clocks after the clock in which `crs` returned high.
- R8: With `defer_chk_en` low, no error arises however long the carrier stays busy. Transmission is permitted 96 ticks after `crs` falls.
- R9: After an abort the block is idle. `tx_ok` stays low even if the carrier goes quiet, until `tx_req` falls and rises again.
- R10: Dropping `tx_req` returns the block to idle, and `tx_ok` is low one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per bit time |
| crs | input | 1 | Carrier sense |
| tx_req | input | 1 | Frame request, held high until the frame is finished |
| retry | input | 1 | Collision retry strobe |
| attempt_n | input | ATT_W | Retransmission attempt number, sampled with `retry` |
| bo_sel | input | 2 | Backoff exponent cap select |
| defer_chk_en | input | 1 | Enables the excessive-deferral watchdog |
| full_duplex | input | 1 | High selects full-duplex mode |
| tx_ok | output | 1 | Transmission permitted |
| bo_busy | output | 1 | Backoff in progress |
| defer_err | output | 1 | Excessive-deferral error pulse |
| tx_abort | output | 1 | Abort pulse for the pending frame |

## Verification
The bench measures backoff length in clocks under several cap selects. It includes attempt numbers above the cap, so a design that did not truncate the exponent, or that counted slots of the wrong length, would give a delay out of range or one that is not a whole number of slots. The deferral watchdog is timed to the exact clock. A design that fired at 24288 ticks instead of after them, or that ignored a carrier restart, would pulse one clock early or some 20000 clocks too soon. The bench also checks that an abort leaves the block quiet while the request stays high, and that a zero attempt count does not start a backoff.

// File: rtl/hdt_pkg.sv
package hdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BACKOFF = 2'd1,
    ST_DEFER   = 2'd2,
    ST_GRANT   = 2'd3
  } hdt_state_e;

  // exponent cap for each backoff-limit select value
  function automatic logic [3:0] bo_cap(input logic [1:0] sel);
    case (sel)
      2'd0:    bo_cap = 4'd10;
      2'd1:    bo_cap = 4'd8;
      2'd2:    bo_cap = 4'd4;
      default: bo_cap = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/hdt_lfsr.sv
module hdt_lfsr #(
  parameter int               W    = 10,
  parameter logic [W-1:0]     TAPS = 10'h240,
  parameter logic [W-1:0]     SEED = 10'h1a5
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd
);
  logic [W-1:0] q;
  logic         fb;

  assign fb  = ^(q & TAPS);
  assign rnd = q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], fb};
  end

  // a nonzero seed must never decay to the stuck all-zero state (R4)
  p_lfsr_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/hdt_backoff.sv
module hdt_backoff
  import hdt_pkg::*;
#(
  parameter int SLOT_BITS = 512,
  parameter int ATT_W     = 5,
  parameter int W         = 10,
  localparam int BW       = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       sel,
  input  logic [ATT_W-1:0] attempt,
  input  logic [W-1:0]     rnd,
  input  logic             run,
  input  logic             tick,
  output logic             zero
);
  localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_BITS - 1);

  // k = min(n, cap)
  function automatic int bo_exp(input logic [1:0] s, input logic [ATT_W-1:0] n);
    int cap;
    cap = int'(bo_cap(s));
    bo_exp = (int'(n) < cap) ? int'(n) : cap;
  endfunction

  // low k bits set
  function automatic logic [W-1:0] low_mask(input int k);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < W; i++) if (i < k) m[i] = 1'b1;
    low_mask = m;
  endfunction

  logic [W-1:0]  slots;
  logic [BW-1:0] bitcnt;
  logic [W-1:0]  bo_mask;
  logic          slot_end;

  assign bo_mask  = low_mask(bo_exp(sel, attempt));
  assign zero     = (slots == '0);
  assign slot_end = run && tick && !zero && (bitcnt == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots  <= '0;
      bitcnt <= '0;
    end else if (load) begin
      slots  <= rnd & bo_mask;
      bitcnt <= '0;
    end else if (slot_end) begin
      slots  <= slots - 1'b1;
      bitcnt <= '0;
    end else if (run && tick && !zero) begin
      bitcnt <= bitcnt + 1'b1;
    end
  end

  p_load_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((slots & ~$past(bo_mask)) == '0));
  p_slots_nonincr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (slots <= $past(slots)));
endmodule

// File: rtl/hdt_defer.sv
module hdt_defer #(
  parameter int DEFER_LIMIT = 24288,
  parameter int IFG_TICKS   = 96,
  localparam int TW         = $clog2(DEFER_LIMIT + 1),
  localparam int GW         = $clog2(IFG_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  input  logic crs,
  input  logic chk_en,
  output logic gap_done,
  output logic expire
);
  localparam logic [TW-1:0] T_LIMIT  = TW'(DEFER_LIMIT);
  localparam logic [GW-1:0] GAP_LAST = GW'(IFG_TICKS - 1);

  logic [TW-1:0] timer;
  logic [GW-1:0] gap;
  logic          crs_q;
  logic          crs_rise;
  logic          step;

  assign crs_rise = crs && !crs_q;
  assign step     = run && !clear && !crs_rise && tick;
  assign gap_done = step && !crs && (gap == GAP_LAST);
  assign expire   = step && chk_en && (timer == T_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crs_q <= 1'b0;
    else        crs_q <= crs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      gap   <= '0;
    end else if (clear || (run && crs_rise)) begin
      timer <= '0;
      gap   <= '0;
    end else if (step) begin
      if (timer != T_LIMIT) timer <= timer + 1'b1;
      if (crs)                   gap <= '0;
      else if (gap != GAP_LAST)  gap <= gap + 1'b1;
    end
  end

  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timer <= T_LIMIT);
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && crs_rise) |=> (timer == '0));
endmodule

// File: rtl/hd_txtime.sv
module hd_txtime
  import hdt_pkg::*;
#(
  parameter int               SLOT_BITS   = 512,
  parameter int               DEFER_LIMIT = 24288,
  parameter int               IFG_TICKS   = 96,
  parameter int               ATT_W       = 5,
  parameter int               LFSR_W      = 10,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 10'h240,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 10'h1a5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             crs,
  input  logic             tx_req,
  input  logic             retry,
  input  logic [ATT_W-1:0] attempt_n,
  input  logic [1:0]       bo_sel,
  input  logic             defer_chk_en,
  input  logic             full_duplex,
  output logic             tx_ok,
  output logic             bo_busy,
  output logic             defer_err,
  output logic             tx_abort
);
  hdt_state_e      state, state_nx;
  logic            req_q;
  logic            req_rise;
  logic            hd_active;
  logic            retry_take;
  logic            bo_load;
  logic            bo_zero;
  logic            df_clear;
  logic            df_run;
  logic            gap_done;
  logic            df_expire;
  logic            defer_abort;
  logic            err_q;
  logic [LFSR_W-1:0] rnd;

  assign req_rise    = tx_req && !req_q;
  assign hd_active   = tx_req && !full_duplex;
  assign retry_take  = hd_active && retry && (state != ST_IDLE);
  assign bo_load     = retry_take && (attempt_n != '0);
  assign df_run      = (state == ST_DEFER);
  assign df_clear    = (retry_take && (attempt_n == '0)) ||
                       (hd_active && !retry_take &&
                        (((state == ST_IDLE) && req_rise) ||
                         ((state == ST_BACKOFF) && bo_zero)));
  assign defer_abort = hd_active && !retry_take && df_run && df_expire && !gap_done;

  hdt_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  hdt_backoff #(.SLOT_BITS(SLOT_BITS), .ATT_W(ATT_W), .W(LFSR_W)) bo_i (
    .clk(clk), .rst_n(rst_n), .load(bo_load), .sel(bo_sel), .attempt(attempt_n),
    .rnd(rnd), .run(state == ST_BACKOFF), .tick(bit_tick), .zero(bo_zero)
  );

  hdt_defer #(.DEFER_LIMIT(DEFER_LIMIT), .IFG_TICKS(IFG_TICKS)) df_i (
    .clk(clk), .rst_n(rst_n), .clear(df_clear), .run(df_run), .tick(bit_tick),
    .crs(crs), .chk_en(defer_chk_en), .gap_done(gap_done), .expire(df_expire)
  );

  always_comb begin
    state_nx = state;
    if (!hd_active)      state_nx = ST_IDLE;
    else if (bo_load)    state_nx = ST_BACKOFF;
    else if (df_clear)   state_nx = ST_DEFER;
    else begin
      case (state)
        ST_DEFER: begin
          if (gap_done)         state_nx = ST_GRANT;
          else if (defer_abort) state_nx = ST_IDLE;
        end
        default: state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      req_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      state <= state_nx;
      req_q <= tx_req;
      err_q <= defer_abort;
    end
  end

  assign tx_ok     = full_duplex || (state == ST_GRANT);
  assign bo_busy   = (state == ST_BACKOFF);
  assign defer_err = err_q;
  assign tx_abort  = err_q;

  p_fd_no_backoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(full_duplex) && full_duplex) |-> !bo_busy);
  p_grant_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_ok) && !full_duplex && $past(!full_duplex)) |-> $past(!crs));
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_err |=> !defer_err);
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (state == ST_IDLE));
  p_drop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> (state == ST_IDLE));
endmodule

// File: tb/hd_txtime_tb_top.sv
module hd_txtime_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 24288;
  localparam int IFG        = 96;
  localparam int SLOT       = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b1;
  logic       crs = 1'b0;
  logic       tx_req = 1'b0;
  logic       retry = 1'b0;
  logic [4:0] attempt_n = '0;
  logic [1:0] bo_sel = '0;
  logic       defer_chk_en = 1'b1;
  logic       full_duplex = 1'b0;
  logic       tx_ok, bo_busy, defer_err, tx_abort;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hd_txtime dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .crs(crs), .tx_req(tx_req),
    .retry(retry), .attempt_n(attempt_n), .bo_sel(bo_sel),
    .defer_chk_en(defer_chk_en), .full_duplex(full_duplex),
    .tx_ok(tx_ok), .bo_busy(bo_busy), .defer_err(defer_err), .tx_abort(tx_abort)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cap of the backoff exponent, written as a lookup of its own
  function automatic int exp_k(input int sel, input int n);
    int cap;
    cap = (sel == 0) ? 10 : (sel == 1) ? 8 : (sel == 2) ? 4 : 1;
    return (n < cap) ? n : cap;
  endfunction

  task automatic fresh_req(input logic carrier);
    tx_req = 1'b0;
    step(2);
    crs = carrier;
    tx_req = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 tx_ok", tx_ok, 0);
    check("R1 bo_busy", bo_busy, 0);
    check("R1 defer_err", defer_err, 0);
    check("R1 tx_abort", tx_abort, 0);
  endtask

  task automatic t_first_attempt();
    fresh_req(1'b0);
    step(96);
    check("R3 tx_ok before gap end", tx_ok, 0);
    step(1);
    check("R3 tx_ok after gap", tx_ok, 1);
  endtask

  task automatic t_backoff(input int sel, input int n);
    int cnt;
    int k;
    k = exp_k(sel, n);
    bo_sel = 2'(sel);
    attempt_n = 5'(n);
    retry = 1'b1;
    step(1);
    retry = 1'b0;
    cnt = 0;
    while (bo_busy && cnt < 20000) begin
      cnt++;
      step(1);
    end
    check($sformatf("R4 busy seen sel=%0d n=%0d", sel, n), int'(cnt >= 1), 1);
    check($sformatf("R4 whole slots sel=%0d n=%0d", sel, n), (cnt - 1) % SLOT, 0);
    check($sformatf("R4 dt bound sel=%0d n=%0d dt=%0d", sel, n, (cnt - 1) / SLOT),
          int'(((cnt - 1) / SLOT) < (1 << k)), 1);
    step(95);
    check("R4 deferral after backoff, not yet", tx_ok, 0);
    step(1);
    check("R4 deferral after backoff, granted", tx_ok, 1);
  endtask

  task automatic t_retry_zero();
    attempt_n = 5'd0;
    retry = 1'b1;
    step(1);
    retry = 1'b0;
    check("R5 no backoff", bo_busy, 0);
    check("R5 tx_ok withdrawn", tx_ok, 0);
    step(95);
    check("R5 before gap", tx_ok, 0);
    step(1);
    check("R5 granted", tx_ok, 1);
  endtask

  task automatic t_req_drop();
    tx_req = 1'b0;
    step(1);
    check("R10 tx_ok after drop", tx_ok, 0);
  endtask

  task automatic t_defer_err();
    int cnt;
    int early;
    defer_chk_en = 1'b1;
    fresh_req(1'b1);
    cnt = 0;
    early = 0;
    while (!defer_err && cnt < LIMIT + 10) begin
      cnt++;
      step(1);
    end
    check("R6 error clock", cnt, LIMIT + 2);
    check("R6 abort with error", tx_abort, 1);
    step(1);
    check("R6 error single pulse", defer_err, 0);
    check("R6 abort single pulse", tx_abort, 0);
    crs = 1'b0;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (tx_ok || defer_err) early++;
    end
    check("R9 idle after abort", early, 0);
  endtask

  task automatic t_defer_restart();
    int cnt;
    fresh_req(1'b1);
    step(20000);
    crs = 1'b0;
    step(1);
    crs = 1'b1;
    cnt = 0;
    while (!defer_err && cnt < LIMIT + 10) begin
      cnt++;
      step(1);
    end
    check("R7 error after restart", cnt, LIMIT + 2);
  endtask

  task automatic t_defer_nochk();
    int errs;
    defer_chk_en = 1'b0;
    fresh_req(1'b1);
    errs = 0;
    for (int i = 0; i < LIMIT + 50; i++) begin
      step(1);
      if (defer_err || tx_abort) errs++;
    end
    check("R8 no error when disabled", errs, 0);
    crs = 1'b0;
    step(95);
    check("R8 before gap", tx_ok, 0);
    step(1);
    check("R8 granted", tx_ok, 1);
    defer_chk_en = 1'b1;
  endtask

  task automatic t_full_duplex();
    int busy;
    full_duplex = 1'b1;
    tx_req = 1'b1;
    crs = 1'b1;
    step(2);
    check("R2 tx_ok in full duplex", tx_ok, 1);
    attempt_n = 5'd3;
    bo_sel = 2'd3;
    retry = 1'b1;
    step(1);
    retry = 1'b0;
    busy = 0;
    for (int i = 0; i < 600; i++) begin
      step(1);
      if (bo_busy || !tx_ok) busy++;
    end
    check("R2 retry ignored", busy, 0);
    full_duplex = 1'b0;
    crs = 1'b0;
    tx_req = 1'b0;
    step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_first_attempt();
    t_backoff(3, 1);
    t_backoff(3, 7);
    t_backoff(0, 2);
    t_backoff(1, 3);
    t_backoff(2, 4);
    t_backoff(2, 9);
    t_retry_zero();
    t_req_drop();
    t_defer_err();
    t_defer_restart();
    t_defer_nochk();
    t_full_duplex();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule